// File: doc/BRIEF.md
# Pulse-Swallow Divider Chain for a Frequency Synthesizer

This block holds the digital half of an integer-N frequency synthesizer. It works in a single clock domain. Two per-cycle enables stand for the edges of the two slow signals: `xtal_tick` marks one period of the crystal oscillator, and `vco_tick` marks one period at the input of the dual-modulus prescaler. A fixed reference counter turns every 800 crystal periods into one reference event. With a 4 MHz crystal this gives a 5 kHz comparison rate.

On the feedback side, a behavioural model of a 64/65 prescaler is steered by two counters: a swallow counter and a main counter. Together they divide the prescaler input by a programmable ratio N. The main count B is the upper bits of N, and the swallow count A is its low six bits, so N = 64·B + A. The split is valid only when A ≤ B, which holds for every ratio from 5306 to 5360 in steps of 6.

A three-state phase-frequency detector compares the reference events with the feedback events. It drives pump-up and pump-down enables toward an external charge pump and loop filter. An active-low enable places the whole chain in standby.

Top module: `pll_divider_chain`

## Requirements
- R1: `ref_pulse` is a one-cycle pulse. The interval between two reference pulses is exactly 800 `xtal_tick` cycles.
- R2: With `vco_tick` high every cycle, the interval between two `fb_pulse` pulses is exactly N cycles for each ratio 5306, 5312, …, 5360.
- R3: In each feedback interval, `mod_sel` (1 = divide by 65) is high for exactly 65·A prescaler-input periods, where A = N[5:0]. It stays low for the whole interval when A = 0 (ratio 5312).
- R4: `presc_pulse` fires exactly B = N[12:6] times per feedback interval. Every `fb_pulse` follows a `presc_pulse` by one cycle.
- R5: `n_ratio` is sampled only at a feedback boundary. Changing it during an interval leaves that interval at the old ratio, and the next interval uses the new one.
- R6: During synchronous reset, `ref_pulse`, `fb_pulse`, `presc_pulse`, `pump_up` and `pump_dn` are 0. The first division after reset uses the default ratio 5360, so with ticks every cycle the first `fb_pulse` appears 5361 cycles after reset is released.
- R7: A reference pulse sets `pump_up`, and a feedback pulse sets `pump_dn`, one cycle later. Each one holds until the other event arrives. The two are never high together.
- R8: When the second of the two events arrives, or when both arrive in the same cycle, both pump enables are low on the following cycle.
- R9: While `en_n` is 1, all pulses and pump enables are 0 from the next cycle, and ticks are ignored. After `en_n` returns to 0, the counting restarts from zero with the present `n_ratio`, so the first `fb_pulse` comes N+1 cycles later.
- R10: Cycles without `vco_tick` do not count. With a tick every second cycle, the feedback interval is 2·N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_n | input | 1 | Operate when 0; standby when 1 |
| xtal_tick | input | 1 | One crystal period elapsed |
| vco_tick | input | 1 | One prescaler-input period elapsed |
| n_ratio | input | 13 | Feedback ratio N; requires N[5:0] ≤ N[12:6] |
| presc_pulse | output | 1 | Prescaler output event |
| mod_sel | output | 1 | Prescaler modulus: 1 = divide by 65, 0 = by 64 |
| ref_pulse | output | 1 | Divided reference event |
| fb_pulse | output | 1 | Divided feedback event |
| pump_up | output | 1 | Charge pump up enable |
| pump_dn | output | 1 | Charge pump down enable |

## Verification
The assertions check several rules on every cycle:
- the two pump enables are never high together;
- a simultaneous pair of events clears the detector;
- standby empties the detector;
- every feedback pulse and every drop of the modulus select follows a prescaler event;
- the main count only grows back at a feedback boundary;
- the swallow count never exceeds the main count.

The exact division ratios need the bench's directed scenarios, because they only show over thousands of cycles. These are the per-channel interval lengths, the 65·A modulus time and the B prescaler events. The same holds for the default ratio after reset, the deferred take-over of a new ratio, the gapped tick pattern and the coincident-edge case.

// File: rtl/pll_div_pkg.sv
// Package: shared constants of the pulse-swallow divider chain.
// Assumes a power-of-two prescaler base (2**PSC_LOG / 2**PSC_LOG+1).
package pll_div_pkg;
    localparam int PKG_RATIO_W   = 13;    // width of the feedback ratio N
    localparam int PKG_PSC_LOG   = 6;     // prescaler base 64, alternate 65
    localparam int PKG_REF_DIV   = 800;   // crystal periods per reference event
    localparam int PKG_DEF_RATIO = 5360;  // ratio used after reset
endpackage

// File: rtl/ref_divider.sv
// Module: ref_divider
// Divides crystal-period enables by DIV and emits a one-cycle event on
// the last period of each group. Held at count zero while not running.
module ref_divider #(
    parameter int DIV = pll_div_pkg::PKG_REF_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic pulse
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count crystal periods and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: an event is produced only by a crystal period and lasts one cycle
    assert_ref_from_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick));
    assert_ref_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/dual_mod_prescaler.sv
// Module: dual_mod_prescaler
// Behavioural model of a 2**PSC_LOG / 2**PSC_LOG+1 prescaler. It counts
// input-period enables and emits one event per prescaler period. The
// modulus is sampled on the last period, so mod_hi must be settled by then.
module dual_mod_prescaler #(
    parameter int PSC_LOG = pll_div_pkg::PKG_PSC_LOG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic mod_hi,
    output logic pulse
);
    localparam int CW = PSC_LOG + 1;
    localparam logic [CW-1:0] LAST_HI = CW'(2 ** PSC_LOG);
    localparam logic [CW-1:0] LAST_LO = CW'(2 ** PSC_LOG - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Pick the terminal count for the selected modulus.
    always_comb last = mod_hi ? LAST_HI : LAST_LO;

    // Advance the period counter on each input period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt >= last) begin
                    cnt   <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: a prescaler event comes from an input period and is one cycle long
    assert_psc_from_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick));
    assert_psc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/swallow_ctrl.sv
// Module: swallow_ctrl
// Main (B) and swallow (A) counters. The modulus stays high while the
// swallow count is non-zero. The last of B prescaler events emits the
// feedback event and reloads both counts from the ratio input.
// Assumes ratio[PSC_LOG-1:0] <= ratio[RATIO_W-1:PSC_LOG] and a non-zero B.
module swallow_ctrl #(
    parameter int RATIO_W   = pll_div_pkg::PKG_RATIO_W,
    parameter int PSC_LOG   = pll_div_pkg::PKG_PSC_LOG,
    parameter int DEF_RATIO = pll_div_pkg::PKG_DEF_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               psc_ev,
    input  logic [RATIO_W-1:0] ratio,
    output logic               mod_hi,
    output logic               fb_pulse
);
    localparam int AW = PSC_LOG;
    localparam int BW = RATIO_W - PSC_LOG;
    localparam logic [RATIO_W-1:0] DEF_W = RATIO_W'(DEF_RATIO);
    localparam logic [BW-1:0] B_ONE = BW'(1);

    logic [AW-1:0] a_cnt;
    logic [BW-1:0] b_cnt;

    // Modulus control follows the remaining swallow count.
    always_comb mod_hi = (a_cnt != '0);

    // Count prescaler events; reload at the feedback boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cnt    <= DEF_W[AW-1:0];
            b_cnt    <= DEF_W[RATIO_W-1:AW];
            fb_pulse <= 1'b0;
        end else if (!run) begin
            a_cnt    <= ratio[AW-1:0];
            b_cnt    <= ratio[RATIO_W-1:AW];
            fb_pulse <= 1'b0;
        end else begin
            fb_pulse <= 1'b0;
            if (psc_ev) begin
                if (b_cnt == B_ONE) begin
                    a_cnt    <= ratio[AW-1:0];
                    b_cnt    <= ratio[RATIO_W-1:AW];
                    fb_pulse <= 1'b1;
                end else begin
                    b_cnt <= b_cnt - 1'b1;
                    if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
                end
            end
        end
    end

    // R4: each feedback event closes a prescaler event
    assert_fb_after_psc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> $past(psc_ev));
    // R3: the modulus drops only on a prescaler boundary while running
    assert_mod_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $fell(mod_hi)) |-> $past(psc_ev));
    // R5: the main count grows back only at the feedback boundary
    assert_reload_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (b_cnt > $past(b_cnt))) |-> fb_pulse);
    // R2: the split keeps the swallow count within the main count
    assert_split_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(a_cnt) <= int'(b_cnt)) && (b_cnt != '0));
endmodule

// File: rtl/phase_freq_det.sv
// Module: phase_freq_det
// Three-state phase-frequency detector on single-cycle events. A
// reference event sets up, a feedback event sets dn, and when both would
// be set the pair clears. Both outputs are cleared while not running.
module phase_freq_det (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_ev,
    input  logic fb_ev,
    output logic up,
    output logic dn
);
    logic up_nx, dn_nx, clr;

    // Next-state terms before the clearing rule.
    always_comb begin
        up_nx = up | ref_ev;
        dn_nx = dn | fb_ev;
        clr   = up_nx & dn_nx;
    end

    // Hold the detector state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_nx & ~clr;
            dn <= dn_nx & ~clr;
        end
    end

    // R7: never both enables together
    assert_pump_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up, dn}));
    // R7: a lone reference event with no pending dn raises up
    assert_up_on_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ref_ev && !fb_ev && !dn) |=> up);
    // R8: coincident events leave the detector empty
    assert_pump_coincide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ev && fb_ev) |=> (!up && !dn));
    // R9: standby empties the detector
    assert_pump_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!up && !dn));
endmodule

// File: rtl/pll_divider_chain.sv
// Module: pll_divider_chain (top)
// Reference divider, prescaler model, swallow/main counters and detector
// of an integer-N synthesizer. All work is in the clk domain; the tick
// inputs stand for crystal and prescaler-input periods.
module pll_divider_chain #(
    parameter int RATIO_W   = pll_div_pkg::PKG_RATIO_W,
    parameter int PSC_LOG   = pll_div_pkg::PKG_PSC_LOG,
    parameter int REF_DIV   = pll_div_pkg::PKG_REF_DIV,
    parameter int DEF_RATIO = pll_div_pkg::PKG_DEF_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_n,
    input  logic               xtal_tick,
    input  logic               vco_tick,
    input  logic [RATIO_W-1:0] n_ratio,
    output logic               presc_pulse,
    output logic               mod_sel,
    output logic               ref_pulse,
    output logic               fb_pulse,
    output logic               pump_up,
    output logic               pump_dn
);
    logic run;

    // Active-low enable to running flag.
    always_comb run = ~en_n;

    ref_divider #(.DIV(REF_DIV)) ref_div_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(xtal_tick), .pulse(ref_pulse)
    );

    dual_mod_prescaler #(.PSC_LOG(PSC_LOG)) psc_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(vco_tick),
        .mod_hi(mod_sel), .pulse(presc_pulse)
    );

    swallow_ctrl #(.RATIO_W(RATIO_W), .PSC_LOG(PSC_LOG), .DEF_RATIO(DEF_RATIO)) swl_i (
        .clk(clk), .rst_n(rst_n), .run(run), .psc_ev(presc_pulse),
        .ratio(n_ratio), .mod_hi(mod_sel), .fb_pulse(fb_pulse)
    );

    phase_freq_det pfd_i (
        .clk(clk), .rst_n(rst_n), .run(run), .ref_ev(ref_pulse),
        .fb_ev(fb_pulse), .up(pump_up), .dn(pump_dn)
    );
endmodule

// File: tb/pll_divider_chain_tb.sv
module pll_divider_chain_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;
    localparam int MAX_WAIT   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b0;
    logic xtal_tick = 1'b0;
    logic vco_tick = 1'b0;
    logic [12:0] n_ratio = 13'd5306;
    logic presc_pulse, mod_sel, ref_pulse, fb_pulse, pump_up, pump_dn;

    int n_cmp = 0;
    int n_bad = 0;
    bit ph = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_divider_chain dut_i (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .xtal_tick(xtal_tick),
        .vco_tick(vco_tick), .n_ratio(n_ratio), .presc_pulse(presc_pulse),
        .mod_sel(mod_sel), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .pump_up(pump_up), .pump_dn(pump_dn)
    );

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        $display("FAIL watchdog: run hung, got %0d cycles expected fewer", WD_LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive inputs for one edge, then sample just after it.
    task automatic cyc(input bit xt, input bit vt);
        @(negedge clk);
        xtal_tick = xt;
        vco_tick  = vt;
        @(posedge clk);
        #1;
    endtask

    task automatic vstep(input bit gap);
        if (gap) begin
            ph = ~ph;
            cyc(1'b0, ph);
        end else begin
            cyc(1'b0, 1'b1);
        end
    endtask

    task automatic wait_fb(input bit gap);
        for (int i = 0; i < MAX_WAIT; i++) begin
            vstep(gap);
            if (fb_pulse) break;
        end
    endtask

    // Called on a sample with fb_pulse high; measures up to the next one.
    task automatic run_fb(input bit gap, input int chg_at, input int chg_val,
                          output int len, output int mods, output int prs);
        len  = 1;
        mods = int'(mod_sel);
        prs  = int'(presc_pulse);
        for (int i = 0; i < MAX_WAIT; i++) begin
            if (len == chg_at) n_ratio = 13'(chg_val);
            vstep(gap);
            if (fb_pulse) break;
            len++;
            mods += int'(mod_sel);
            prs  += int'(presc_pulse);
        end
    endtask

    task automatic enter_standby(input int cycles);
        en_n = 1'b1;
        for (int i = 0; i < cycles; i++) cyc(1'b0, 1'b0);
        en_n = 1'b0;
    endtask

    task automatic t_reset();
        int len, mods, prs, first;
        rst_n = 1'b0;
        n_ratio = 13'd5306;
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b1);
            chk("R6", "outputs in reset",
                int'(presc_pulse) + int'(fb_pulse) + int'(ref_pulse) + int'(pump_up) + int'(pump_dn), 0);
        end
        rst_n = 1'b1;
        first = 0;
        for (int i = 1; i < MAX_WAIT; i++) begin
            cyc(1'b0, 1'b1);
            if (fb_pulse) begin
                first = i;
                break;
            end
        end
        chk("R6", "first feedback after reset (default 5360)", first, 5361);
        run_fb(1'b0, 0, 0, len, mods, prs);
        chk("R5", "ratio loaded at first boundary", len, 5306);
    endtask

    task automatic t_sweep();
        int len, mods, prs, prev;
        prev = 5306;
        for (int k = 1; k <= 11; k++) begin
            if (k <= 10) n_ratio = 13'(5300 + 6 * k);
            run_fb(1'b0, 0, 0, len, mods, prs);
            chk("R2", $sformatf("interval for N=%0d", prev), len, prev);
            chk("R3", $sformatf("mod_sel time for N=%0d", prev), mods, 65 * (prev % 64));
            chk("R4", $sformatf("prescaler events for N=%0d", prev), prs, prev / 64);
            if (k <= 10) prev = 5300 + 6 * k;
        end
    endtask

    task automatic t_midchange();
        int len, mods, prs;
        run_fb(1'b0, 1200, 5330, len, mods, prs);
        chk("R5", "interval with mid-cycle change keeps old N", len, 5360);
        run_fb(1'b0, 0, 0, len, mods, prs);
        chk("R5", "next interval uses new N", len, 5330);
    endtask

    task automatic t_gapped();
        int len, mods, prs;
        n_ratio = 13'd5342;
        wait_fb(1'b1);
        run_fb(1'b1, 0, 0, len, mods, prs);
        chk("R10", "gapped ticks interval", len, 2 * 5342);
        chk("R10", "gapped mod_sel cycles", mods, 2 * 65 * 30);
        chk("R4", "gapped prescaler events", prs, 83);
    endtask

    task automatic t_ref();
        int len;
        for (int i = 0; i < MAX_WAIT; i++) begin
            cyc(1'b1, 1'b0);
            if (ref_pulse) break;
        end
        len = 1;
        for (int i = 0; i < MAX_WAIT; i++) begin
            cyc(1'b1, 1'b0);
            if (ref_pulse) break;
            len++;
        end
        chk("R1", "reference interval", len, 800);
    endtask

    task automatic t_standby();
        int busy, first;
        n_ratio = 13'd5318;
        en_n = 1'b1;
        cyc(1'b1, 1'b1);
        busy = 0;
        for (int i = 0; i < 1000; i++) begin
            cyc(1'b1, 1'b1);
            busy += int'(presc_pulse) + int'(fb_pulse) + int'(ref_pulse) + int'(pump_up) + int'(pump_dn);
        end
        chk("R9", "activity during standby", busy, 0);
        en_n = 1'b0;
        first = 0;
        for (int i = 1; i < MAX_WAIT; i++) begin
            cyc(1'b0, 1'b1);
            if (fb_pulse) begin
                first = i;
                break;
            end
        end
        chk("R9", "first feedback after standby", first, 5319);
        cyc(1'b0, 1'b1);
        chk("R7", "pump_dn after lone feedback", int'(pump_dn), 1);
        chk("R7", "pump_up after lone feedback", int'(pump_up), 0);
    endtask

    task automatic t_pfd();
        int n;
        enter_standby(3);
        for (int i = 0; i < MAX_WAIT; i++) begin
            cyc(1'b1, 1'b0);
            if (ref_pulse) break;
        end
        cyc(1'b1, 1'b0);
        chk("R7", "pump_up after reference", int'(pump_up), 1);
        chk("R7", "pump_dn after reference", int'(pump_dn), 0);
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b0);
        chk("R7", "pump_up held", int'(pump_up), 1);
        wait_fb(1'b0);
        chk("R7", "pump_up still high at feedback", int'(pump_up), 1);
        cyc(1'b0, 1'b1);
        chk("R8", "both clear after second event", int'(pump_up) + int'(pump_dn), 0);
        wait_fb(1'b0);
        cyc(1'b0, 1'b1);
        chk("R7", "pump_dn after feedback", int'(pump_dn), 1);
        en_n = 1'b1;
        cyc(1'b0, 1'b1);
        chk("R9", "pumps cleared by standby", int'(pump_up) + int'(pump_dn), 0);
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0);
        en_n = 1'b0;
        n = 5318;
        for (int i = 1; i <= n + 2; i++) begin
            cyc(i >= n - 798, 1'b1);
            if (i == n) chk("R8", "pumps idle before coincidence", int'(pump_up) + int'(pump_dn), 0);
            if (i == n + 1) begin
                chk("R8", "reference at coincidence", int'(ref_pulse), 1);
                chk("R8", "feedback at coincidence", int'(fb_pulse), 1);
            end
            if (i == n + 2) chk("R8", "pumps after coincidence", int'(pump_up) + int'(pump_dn), 0);
        end
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_midchange();
        t_gapped();
        t_ref();
        t_standby();
        t_pfd();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule